// File: doc/BRIEF.md
# Dataflow Actor Firing Scheduler

This block decides, step by step, which action of a hardware dataflow actor may run next. The actor has four actions, two input token queues and one output token queue. Each queue reports its state as a level: how many tokens an input queue holds, and how many free slots the output queue has. Each action also has a guard bit driven by the action logic. The scheduler tests every action against all of these and against a small control state machine that belongs to the actor. It then starts the winning action with a one-cycle fire strobe and waits for the action's done strobe before it looks again.

Every action has its own configuration, set by parameters. This covers how many tokens it takes from each input, how many it writes to the output, the set of control states in which it may run, and the control state it leaves behind. When several actions qualify at once, the lowest-numbered one wins.

Internally a three-state sequencer paces the handshake. IDLE evaluates eligibility on every cycle. On the START transition it moves to FIRE, where the fire strobe is high for exactly one cycle. On the ISSUE transition it moves to WAIT, where it holds until done. On the RETIRE transition it returns to IDLE and loads the actor's next control state. Done is honoured only in WAIT.

Top module: `actor_sched`

## Requirements
- R1: After reset the actor control state is INIT_ST (0 by default), fire is all zero and busy is low.
- R2: An action qualifies only if in0_lvl and in1_lvl are each at least its consumption rate on that port. The defaults are: action 0 takes 2 from in0; action 1 takes 1 from in0 and 1 from in1; action 2 takes 1 from in1; action 3 takes nothing.
- R3: An action qualifies only if out_room is at least the number of tokens it produces. The defaults are 1, 1, 0 and 2 for actions 0 to 3.
- R4: An action whose guard bit (guard[a] for action a) is low never fires.
- R5: An action fires only in a control state its mask allows. The default masks are: action 0 in states 0 and 1; action 1 in states 1 and 2; action 2 in any state; action 3 in states 2 and 3.
- R6: When several actions qualify in the same cycle, the lowest action index fires.
- R7: fire is one-hot, with bit a meaning action a. It is high for exactly one cycle and rises on the cycle after the qualifying inputs are sampled.
- R8: From the fire strobe until done is accepted, busy is high and no further fire strobe occurs, whatever the inputs do.
- R9: The control state keeps its value at fire. It changes to the fired action's next state on the clock edge where done is accepted. The default next states are 1, 2, 3 and 0 for actions 0 to 3.
- R10: A done pulse while no action is in flight has no effect on the control state, fire or busy.
- R11: While no action qualifies, the scheduler stays idle (fire zero, busy low) and re-evaluates every cycle. It fires on the cycle after an action becomes eligible.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in0_lvl | input | CW | Tokens waiting in input queue 0 |
| in1_lvl | input | CW | Tokens waiting in input queue 1 |
| out_room | input | CW | Free slots in the output queue |
| guard | input | N_ACT | Guard bit per action |
| done | input | 1 | Completion strobe from the running action |
| fire | output | N_ACT | One-cycle one-hot start strobe |
| busy | output | 1 | An action is in flight |
| fsm_st | output | $clog2(N_ST) | Actor control state |

## Verification
The bench first holds input levels one token or one slot short of what an action needs, which separates a correct comparison against the rate from an off-by-one threshold. It then offers several actions at once in different control states, with guards toggled. This shows whether the priority order, the guard and the state mask each block an action independently. Done pulses are sent both while idle and in flight, and eligibility is kept present throughout a busy period. Together these show that the control state moves only on an accepted completion and that no action overlaps another.

// File: rtl/sched_pkg.sv
package sched_pkg;

    // Sequencer phases of the firing handshake.
    typedef enum logic [1:0] {
        C_IDLE = 2'd0,   // evaluate eligibility every cycle
        C_FIRE = 2'd1,   // fire strobe is high this cycle
        C_WAIT = 2'd2    // action running, waiting for done
    } ctl_e;

endpackage

// File: rtl/act_elig.sv
module act_elig #(
    parameter int              CW       = 4,
    parameter int              RW       = 2,
    parameter int              N_ST     = 4,
    parameter logic [RW-1:0]   NEED_IN0 = '0,
    parameter logic [RW-1:0]   NEED_IN1 = '0,
    parameter logic [RW-1:0]   NEED_OUT = '0,
    parameter logic [N_ST-1:0] ST_MASK  = '1
) (
    input  logic [CW-1:0]               in0_lvl,
    input  logic [CW-1:0]               in1_lvl,
    input  logic [CW-1:0]               out_room,
    input  logic                        guard,
    input  logic [$clog2(N_ST)-1:0]     st,
    output logic                        ok
);
    localparam logic [CW-1:0] N0 = CW'(NEED_IN0);
    localparam logic [CW-1:0] N1 = CW'(NEED_IN1);
    localparam logic [CW-1:0] NO = CW'(NEED_OUT);

    logic tok_ok;
    logic room_ok;
    logic st_ok;

    always_comb begin
        tok_ok  = (in0_lvl >= N0) && (in1_lvl >= N1);
        room_ok = (out_room >= NO);
        st_ok   = ST_MASK[st];
        ok      = tok_ok && room_ok && st_ok && guard;
    end

endmodule

// File: rtl/prio_pick.sv
module prio_pick #(
    parameter int N  = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic [N-1:0]  oh,
    output logic [IW-1:0] idx,
    output logic          any
);
    logic found;

    // Lowest index has the highest static priority.
    always_comb begin
        oh    = '0;
        idx   = '0;
        found = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !found) begin
                oh[i] = 1'b1;
                idx   = IW'(i);
                found = 1'b1;
            end
        end
        any = found;
    end

endmodule

// File: rtl/sched_ctl.sv
module sched_ctl
    import sched_pkg::*;
#(
    parameter int N_ACT = 4,
    parameter int N_ST  = 4,
    parameter logic [N_ACT*$clog2(N_ST)-1:0] NEXT_TAB = '0,
    parameter logic [$clog2(N_ST)-1:0]       INIT_ST  = '0,
    localparam int SW = $clog2(N_ST),
    localparam int IW = (N_ACT > 1) ? $clog2(N_ACT) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             any_ok,
    input  logic [N_ACT-1:0] pick_oh,
    input  logic [IW-1:0]    pick_idx,
    input  logic             done,
    output logic [N_ACT-1:0] fire,
    output logic             busy,
    output logic [SW-1:0]    st
);
    ctl_e             ctl_q, ctl_d;
    logic [N_ACT-1:0] grant_q;
    logic [IW-1:0]    gidx_q;
    logic [SW-1:0]    st_q;

    // Transitions: START (IDLE->FIRE), ISSUE (FIRE->WAIT), RETIRE (WAIT->IDLE).
    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q)
            C_IDLE:  if (any_ok) ctl_d = C_FIRE;
            C_FIRE:  ctl_d = C_WAIT;
            C_WAIT:  if (done) ctl_d = C_IDLE;
            default: ctl_d = C_IDLE;
        endcase
    end

    // State register, captured grant and actor control state.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q   <= C_IDLE;
            grant_q <= '0;
            gidx_q  <= '0;
            st_q    <= INIT_ST;
        end else begin
            ctl_q <= ctl_d;
            if (ctl_q == C_IDLE && any_ok) begin
                grant_q <= pick_oh;
                gidx_q  <= pick_idx;
            end
            if (ctl_q == C_WAIT && done) begin
                st_q <= NEXT_TAB[int'(gidx_q)*SW +: SW];
            end
        end
    end

    // Outputs decoded from the sequencer phase.
    always_comb begin
        fire = '0;
        busy = 1'b0;
        unique case (ctl_q)
            C_IDLE:  busy = 1'b0;
            C_FIRE:  begin fire = grant_q; busy = 1'b1; end
            C_WAIT:  busy = 1'b1;
            default: busy = 1'b0;
        endcase
        st = st_q;
    end

endmodule

// File: rtl/actor_sched.sv
module actor_sched #(
    parameter int N_ACT = 4,
    parameter int N_ST  = 4,
    parameter int CW    = 4,
    parameter int RW    = 2,
    parameter logic [N_ACT*RW-1:0]           RATE_IN0 = 8'h06,
    parameter logic [N_ACT*RW-1:0]           RATE_IN1 = 8'h14,
    parameter logic [N_ACT*RW-1:0]           RATE_OUT = 8'h85,
    parameter logic [N_ACT*N_ST-1:0]         ALLOW    = 16'hCF63,
    parameter logic [N_ACT*$clog2(N_ST)-1:0] NEXT_TAB = 8'h39,
    parameter logic [$clog2(N_ST)-1:0]       INIT_ST  = '0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [CW-1:0]           in0_lvl,
    input  logic [CW-1:0]           in1_lvl,
    input  logic [CW-1:0]           out_room,
    input  logic [N_ACT-1:0]        guard,
    input  logic                    done,
    output logic [N_ACT-1:0]        fire,
    output logic                    busy,
    output logic [$clog2(N_ST)-1:0] fsm_st
);
    localparam int SW = $clog2(N_ST);
    localparam int IW = (N_ACT > 1) ? $clog2(N_ACT) : 1;

    logic [N_ACT-1:0] ok;
    logic [N_ACT-1:0] pick_oh;
    logic [IW-1:0]    pick_idx;
    logic             any_ok;
    logic [SW-1:0]    st;

    for (genvar a = 0; a < N_ACT; a++) begin : g_act
        act_elig #(
            .CW       (CW),
            .RW       (RW),
            .N_ST     (N_ST),
            .NEED_IN0 (RATE_IN0[a*RW +: RW]),
            .NEED_IN1 (RATE_IN1[a*RW +: RW]),
            .NEED_OUT (RATE_OUT[a*RW +: RW]),
            .ST_MASK  (ALLOW[a*N_ST +: N_ST])
        ) u_elig (
            .in0_lvl  (in0_lvl),
            .in1_lvl  (in1_lvl),
            .out_room (out_room),
            .guard    (guard[a]),
            .st       (st),
            .ok       (ok[a])
        );
    end

    prio_pick #(.N(N_ACT)) u_pick (
        .req (ok),
        .oh  (pick_oh),
        .idx (pick_idx),
        .any (any_ok)
    );

    sched_ctl #(
        .N_ACT    (N_ACT),
        .N_ST     (N_ST),
        .NEXT_TAB (NEXT_TAB),
        .INIT_ST  (INIT_ST)
    ) u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .any_ok   (any_ok),
        .pick_oh  (pick_oh),
        .pick_idx (pick_idx),
        .done     (done),
        .fire     (fire),
        .busy     (busy),
        .st       (st)
    );

    assign fsm_st = st;

endmodule

// File: rtl/sched_chk.sv
module sched_chk #(
    parameter int N_ACT = 4,
    parameter int N_ST  = 4,
    parameter int CW    = 4,
    parameter int RW    = 2,
    parameter logic [N_ACT*RW-1:0]   RATE_IN0 = '0,
    parameter logic [N_ACT*RW-1:0]   RATE_IN1 = '0,
    parameter logic [N_ACT*RW-1:0]   RATE_OUT = '0,
    parameter logic [N_ACT*N_ST-1:0] ALLOW    = '1
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [CW-1:0]           in0_lvl,
    input logic [CW-1:0]           in1_lvl,
    input logic [CW-1:0]           out_room,
    input logic [N_ACT-1:0]        guard,
    input logic                    done,
    input logic [N_ACT-1:0]        fire,
    input logic                    busy,
    input logic [$clog2(N_ST)-1:0] fsm_st
);
    a_r7_fire_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fire));

    a_r7_fire_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (|fire) |=> (fire == '0));

    a_r8_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (fire == '0));

    a_r9_hold_at_fire: assert property (@(posedge clk) disable iff (!rst_n)
        (|fire) |=> $stable(fsm_st));

    a_r9_move_on_done_only: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> $stable(fsm_st));

    a_r10_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(fsm_st));

    for (genvar a = 0; a < N_ACT; a++) begin : g_chk
        localparam logic [CW-1:0] N0 = CW'(RATE_IN0[a*RW +: RW]);
        localparam logic [CW-1:0] N1 = CW'(RATE_IN1[a*RW +: RW]);
        localparam logic [CW-1:0] NO = CW'(RATE_OUT[a*RW +: RW]);
        localparam logic [N_ST-1:0] MASK = ALLOW[a*N_ST +: N_ST];

        a_r5_state_allows: assert property (@(posedge clk) disable iff (!rst_n)
            fire[a] |-> MASK[fsm_st]);

        a_r2_tokens_present: assert property (@(posedge clk) disable iff (!rst_n)
            fire[a] |-> ($past(in0_lvl) >= N0 && $past(in1_lvl) >= N1));

        a_r3_room_present: assert property (@(posedge clk) disable iff (!rst_n)
            fire[a] |-> ($past(out_room) >= NO));

        a_r4_guard_true: assert property (@(posedge clk) disable iff (!rst_n)
            fire[a] |-> $past(guard[a]));
    end

endmodule

bind actor_sched sched_chk #(
    .N_ACT    (N_ACT),
    .N_ST     (N_ST),
    .CW       (CW),
    .RW       (RW),
    .RATE_IN0 (RATE_IN0),
    .RATE_IN1 (RATE_IN1),
    .RATE_OUT (RATE_OUT),
    .ALLOW    (ALLOW)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in0_lvl  (in0_lvl),
    .in1_lvl  (in1_lvl),
    .out_room (out_room),
    .guard    (guard),
    .done     (done),
    .fire     (fire),
    .busy     (busy),
    .fsm_st   (fsm_st)
);

// File: tb/sim_actor_sched.sv
`timescale 1ns/1ps
module sim_actor_sched;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] in0_lvl = '0;
    logic [3:0] in1_lvl = '0;
    logic [3:0] out_room = '0;
    logic [3:0] guard = '0;
    logic       done = 1'b0;
    logic [3:0] fire;
    logic       busy;
    logic [1:0] fsm_st;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  finished = 1'b0;

    always #2 clk = ~clk;

    actor_sched u0 (
        .clk(clk), .rst_n(rst_n), .in0_lvl(in0_lvl), .in1_lvl(in1_lvl),
        .out_room(out_room), .guard(guard), .done(done),
        .fire(fire), .busy(busy), .fsm_st(fsm_st)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive(input int a0, input int a1, input int room, input int g);
        in0_lvl  = 4'(a0);
        in1_lvl  = 4'(a1);
        out_room = 4'(room);
        guard    = 4'(g);
    endtask

    // Pulse done in WAIT, then empty all queues (stub consumed the tokens).
    task automatic retire();
        @(negedge clk) done = 1'b1;
        @(negedge clk) done = 1'b0;
        drive(0, 0, 0, 0);
    endtask

    // Inputs applied now; fire expected at next negedge, then one full retire.
    task automatic fire_case(input int a0, input int a1, input int room, input int g,
                             input int exp_fire, input int exp_next, input string req);
        drive(a0, a1, room, g);
        @(negedge clk);
        chk(fire == 4'(exp_fire), req, fire, exp_fire);
        @(negedge clk);
        chk(fire == 4'd0 && busy, "R7 strobe one cycle / R8 busy", fire, 0);
        retire();
        chk(fsm_st == 2'(exp_next) && !busy, "R9 next state on done", fsm_st, exp_next);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(fsm_st == 2'd0 && fire == 4'd0 && !busy, "R1 in reset", fsm_st, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(fsm_st == 2'd0 && fire == 4'd0 && !busy, "R1 after reset", fire, 0);
    endtask

    task automatic t_short_then_ready();
        drive(1, 0, 0, 15);            // action 0 one token short, no room
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(fire == 4'd0 && !busy, "R11 idle / R2 in0 short", fire, 0);
        end
        drive(2, 0, 1, 15);
        @(negedge clk);
        chk(fire == 4'b0001, "R11 fires next cycle", fire, 1);
        @(negedge clk);
        chk(fire == 4'd0 && busy, "R7 one-cycle strobe", fire, 0);
        chk(fsm_st == 2'd0, "R9 unchanged at fire", fsm_st, 0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(fire == 4'd0 && busy, "R8 no refire while busy", fire, 0);
        end
        retire();
        chk(fsm_st == 2'd1, "R9 state after action 0", fsm_st, 1);
    endtask

    task automatic t_priority();
        // state 1: actions 0, 1 and 2 all qualify
        fire_case(2, 1, 1, 15, 4'b0001, 1, "R6 lowest index wins");
    endtask

    task automatic t_guard();
        fire_case(2, 1, 1, 4'b1110, 4'b0010, 2, "R4 guard low blocks action 0");
    endtask

    task automatic t_state_mask();
        // state 2: action 0 has tokens and room but is masked out
        fire_case(2, 1, 2, 15, 4'b0010, 2, "R5 state mask blocks action 0");
    endtask

    task automatic t_room();
        drive(0, 0, 1, 15);            // action 3 needs two slots
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(fire == 4'd0 && !busy, "R3 room short", fire, 0);
        end
        fire_case(0, 0, 2, 15, 4'b1000, 0, "R3 room enough");
    endtask

    task automatic t_in1();
        fire_case(0, 1, 0, 15, 4'b0100, 3, "R2 in1 token");
    endtask

    task automatic t_done_idle();
        drive(0, 0, 0, 15);
        @(negedge clk) done = 1'b1;
        @(negedge clk) done = 1'b0;
        chk(fsm_st == 2'd3 && fire == 4'd0 && !busy, "R10 stray done", fsm_st, 3);
        @(negedge clk);
        chk(fsm_st == 2'd3 && fire == 4'd0, "R10 stray done later", fsm_st, 3);
    endtask

    task automatic t_hold();
        drive(0, 1, 2, 15);            // state 3: actions 2 and 3 qualify
        @(negedge clk);
        chk(fire == 4'b0100, "R6 action 2 over 3", fire, 4);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(fire == 4'd0 && busy, "R8 eligible inputs held, no fire", fire, 0);
        end
        retire();
        chk(fsm_st == 2'd3, "R9 state after action 2", fsm_st, 3);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_short_then_ready();
        t_priority();
        t_guard();
        t_state_mask();
        t_room();
        t_in1();
        t_done_idle();
        t_hold();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule